// File: doc/BRIEF.md
# Variant-Aware Load/Store Opcode Decoder

This block decodes one 16-bit opcode region (bit 15 set, bit 14 clear, bit 12 clear) of an 8-bit RISC microcontroller's instruction set. The meaning of a word in this region depends on which core variant the chip is built as. On the full core the region holds load and store instructions that add a 6-bit displacement to a pointer register. On the reduced core the same bits hold single-word direct loads and stores. These reach a 128-byte data window, and their address bits are scattered across the word. A static configuration pin chooses the interpretation, so one decoder netlist can serve both core builds.

Instruction words enter through a valid/ready stream and decode results leave through another. A word is taken on a clock edge where `in_valid` and `in_ready` are both high. While `out_valid` is high and `out_ready` is low, the result is held unchanged and `in_ready` stays low. With the default `REG_OUT = 1`, results appear one cycle after the word is accepted, and a new word may be accepted in the same cycle the held result is consumed. With `REG_OUT = 0` the path is purely combinational and ready passes straight through.

Top module: `ldst_variant_decoder`

## Requirements
- R1: After reset `out_valid` is low and stays low until a word is accepted.
- R2: In full mode (`cfg_reduced` = 0), a word in the region decodes as a displacement store (op 4) when bit 9 is 1 and as a displacement load (op 3) when bit 9 is 0. `out_ptr_y` equals bit 3 (1 = Y pointer, 0 = Z pointer) and `out_addr` is zero.
- R3: In full mode the displacement is {bit13, bit11, bit10, bit2, bit1, bit0} (MSB first) and the register index is bits 8:4. Word 0xA400 gives a load with register 0 and displacement 40.
- R4: In reduced mode (`cfg_reduced` = 1), a region word with bit 13 set decodes as a direct store (op 2) when bit 11 is 1 and as a direct load (op 1) when bit 11 is 0. `out_ptr_y` and `out_disp` are zero.
- R5: In reduced mode the register index is 16 plus bits 7:4, so it always lies in 16..31.
- R6: In reduced mode the data address is {~bit8, bit8, bit10, bit9, bit3, bit2, bit1, bit0} (MSB first), so it always lies in 0x40..0xBF. Word 0xA400 gives register 16 and address 0xA0.
- R7: The two interpretations never mix. Reduced mode never reports op 3 or 4, and a region word with bit 13 clear is illegal (op 0) there. Full mode never reports op 1 or 2.
- R8: A word outside the region (bit 15 = 0, bit 14 = 1 or bit 12 = 1) is illegal (op 0) in both modes. An illegal result has every other field at zero.
- R9: When `out_valid` is high and `out_ready` is low, the output fields hold steady and `in_ready` is low. With `REG_OUT` = 1, an accepted word shows its result in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_reduced | input | 1 | Static variant select: 1 = reduced core, 0 = full core |
| in_valid | input | 1 | Instruction word is valid |
| in_ready | output | 1 | Decoder can accept a word |
| in_word | input | 16 | Instruction word |
| out_valid | output | 1 | Decode result is valid |
| out_ready | input | 1 | Consumer accepts the result |
| out_op | output | 3 | Class: 0 illegal, 1 load-direct, 2 store-direct, 3 load-displacement, 4 store-displacement |
| out_ptr_y | output | 1 | Pointer for displacement forms: 1 = Y, 0 = Z |
| out_reg | output | 5 | Destination or source register index |
| out_disp | output | 6 | Displacement |
| out_addr | output | 8 | Direct data address |

## Verification
On every cycle, the assertions check the properties that hold for any word. A direct result always has an address inside 0x40..0xBF and a register index of at least 16. Each mode reports only its own operation classes. Illegal results carry zero fields. Held outputs stay stable under back-pressure, and an accepted word yields a valid result one cycle later. The exact bit assembly can only be shown by the bench's scenarios: the scrambled address, the split displacement, the load/store and pointer bits, and the worked word 0xA400 decoded both ways. The bench also checks words at the edges of the address window and a stall followed by a same-cycle hand-over.

// File: rtl/ldst_dec_pkg.sv
`timescale 1ns/1ps
package ldst_dec_pkg;
  localparam int INSN_W = 16;
  localparam int REG_W  = 5;
  localparam int DISP_W = 6;
  localparam int ADDR_W = 8;
  localparam int OP_W   = 3;

  typedef enum logic [OP_W-1:0] {
    OP_ILLEGAL   = 3'd0,
    OP_LD_DIRECT = 3'd1,
    OP_ST_DIRECT = 3'd2,
    OP_LD_DISP   = 3'd3,
    OP_ST_DISP   = 3'd4
  } op_e;

  typedef struct packed {
    op_e               op;
    logic              ptr_y;
    logic [REG_W-1:0]  rd;
    logic [DISP_W-1:0] disp;
    logic [ADDR_W-1:0] addr;
  } dec_t;

  localparam int DEC_W = $bits(dec_t);
endpackage

// File: rtl/ldst_full_dec.sv
`timescale 1ns/1ps
// Full-core interpretation: pointer plus 6-bit displacement.
module ldst_full_dec
  import ldst_dec_pkg::*;
(
  input  logic [INSN_W-1:0] word,
  output dec_t              dec
);
  logic in_region;
  assign in_region = word[15] & ~word[14] & ~word[12];

  always_comb begin
    dec    = '0;
    dec.op = OP_ILLEGAL;
    if (in_region) begin
      dec.op    = word[9] ? OP_ST_DISP : OP_LD_DISP;
      dec.ptr_y = word[3];
      dec.rd    = word[8:4];
      dec.disp  = {word[13], word[11:10], word[2:0]};
    end
  end
endmodule

// File: rtl/ldst_reduced_dec.sv
`timescale 1ns/1ps
// Reduced-core interpretation: one-word direct access to a 128-byte window.
module ldst_reduced_dec
  import ldst_dec_pkg::*;
(
  input  logic [INSN_W-1:0] word,
  output dec_t              dec
);
  logic in_region;
  assign in_region = word[15] & ~word[14] & ~word[12];

  always_comb begin
    dec    = '0;
    dec.op = OP_ILLEGAL;
    if (in_region && word[13]) begin
      dec.op   = word[11] ? OP_ST_DIRECT : OP_LD_DIRECT;
      dec.rd   = {1'b1, word[7:4]};
      dec.addr = {~word[8], word[8], word[10], word[9], word[3:0]};
    end
  end
endmodule

// File: rtl/ldst_out_stage.sv
`timescale 1ns/1ps
// Optional one-entry valid/ready register stage.
module ldst_out_stage #(
  parameter int W       = 8,
  parameter bit REG_OUT = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  generate
    if (REG_OUT) begin : g_reg
      logic         v_q;
      logic [W-1:0] d_q;
      assign in_ready  = ~v_q | out_ready;
      assign out_valid = v_q;
      assign out_data  = d_q;
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          v_q <= 1'b0;
          d_q <= '0;
        end else if (in_ready) begin
          v_q <= in_valid;
          if (in_valid) d_q <= in_data;
        end
      end
    end else begin : g_comb
      assign in_ready  = out_ready;
      assign out_valid = in_valid;
      assign out_data  = in_data;
    end
  endgenerate
endmodule

// File: rtl/ldst_variant_decoder.sv
`timescale 1ns/1ps
module ldst_variant_decoder
  import ldst_dec_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_reduced,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [INSN_W-1:0] in_word,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [OP_W-1:0]   out_op,
  output logic              out_ptr_y,
  output logic [REG_W-1:0]  out_reg,
  output logic [DISP_W-1:0] out_disp,
  output logic [ADDR_W-1:0] out_addr
);
  dec_t full_d, red_d, sel_d, res_d;
  logic [DEC_W-1:0] res_bits;

  ldst_full_dec    u_full (.word(in_word), .dec(full_d));
  ldst_reduced_dec u_red  (.word(in_word), .dec(red_d));

  assign sel_d = cfg_reduced ? red_d : full_d;

  ldst_out_stage #(.W(DEC_W), .REG_OUT(REG_OUT)) u_stage (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .in_data  (sel_d),
    .out_valid(out_valid),
    .out_ready(out_ready),
    .out_data (res_bits)
  );

  assign res_d     = dec_t'(res_bits);
  assign out_op    = res_d.op;
  assign out_ptr_y = res_d.ptr_y;
  assign out_reg   = res_d.rd;
  assign out_disp  = res_d.disp;
  assign out_addr  = res_d.addr;
endmodule

// File: rtl/ldst_dec_checker.sv
`timescale 1ns/1ps
module ldst_dec_checker
  import ldst_dec_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_reduced,
  input logic              in_valid,
  input logic              in_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic [OP_W-1:0]   out_op,
  input logic              out_ptr_y,
  input logic [REG_W-1:0]  out_reg,
  input logic [DISP_W-1:0] out_disp,
  input logic [ADDR_W-1:0] out_addr
);
  logic is_direct, is_disp;
  assign is_direct = (out_op == OP_LD_DIRECT) || (out_op == OP_ST_DIRECT);
  assign is_disp   = (out_op == OP_LD_DISP)   || (out_op == OP_ST_DISP);

  a_r6_addr_window: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && is_direct) |-> (out_addr[7] != out_addr[6]));

  a_r5_reg_upper: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && is_direct) |-> out_reg[4]);

  a_r7_reduced_no_disp: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && cfg_reduced) |-> !is_disp);

  a_r7_full_no_direct: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !cfg_reduced) |-> !is_direct);

  a_r8_illegal_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_op == OP_ILLEGAL) |->
      (!out_ptr_y && out_reg == '0 && out_disp == '0 && out_addr == '0));

  a_r2_disp_no_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && is_disp) |-> (out_addr == '0));

  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_op) && $stable(out_reg)
      && $stable(out_disp) && $stable(out_addr) && $stable(out_ptr_y)));

  a_r9_stall_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  generate
    if (REG_OUT) begin : g_lat
      a_r9_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> out_valid);
    end
  endgenerate
endmodule

bind ldst_variant_decoder ldst_dec_checker #(.REG_OUT(REG_OUT)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cfg_reduced(cfg_reduced),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_op     (out_op),
  .out_ptr_y  (out_ptr_y),
  .out_reg    (out_reg),
  .out_disp   (out_disp),
  .out_addr   (out_addr)
);

// File: tb/ldst_variant_decoder_bench.sv
`timescale 1ns/1ps
module ldst_variant_decoder_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_reduced = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [15:0] in_word = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [2:0]  out_op;
  logic        out_ptr_y;
  logic [4:0]  out_reg;
  logic [5:0]  out_disp;
  logic [7:0]  out_addr;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  ldst_variant_decoder u_ldst_variant_decoder (
    .clk(clk), .rst_n(rst_n), .cfg_reduced(cfg_reduced),
    .in_valid(in_valid), .in_ready(in_ready), .in_word(in_word),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_op(out_op), .out_ptr_y(out_ptr_y), .out_reg(out_reg),
    .out_disp(out_disp), .out_addr(out_addr)
  );

  // Packed expectation: {op[2:0], ptr_y, reg[4:0], disp[5:0], addr[7:0]}
  function automatic logic [22:0] pack(input logic [2:0] op, input logic p,
      input logic [4:0] r, input logic [5:0] d, input logic [7:0] a);
    return {op, p, r, d, a};
  endfunction

  // Expected decode written from the requirement text.
  function automatic logic [22:0] expect_of(input logic [15:0] w, input logic red);
    logic region;
    region = (w[15] == 1'b1) && (w[14] == 1'b0) && (w[12] == 1'b0);
    if (!region) return '0;                                   // R8
    if (red) begin
      if (w[13] == 1'b0) return '0;                           // R7
      return pack(w[11] ? 3'd2 : 3'd1, 1'b0, 5'd16 + {1'b0, w[7:4]}, 6'd0,
                  {~w[8], w[8], w[10], w[9], w[3], w[2], w[1], w[0]});  // R4 R5 R6
    end
    return pack(w[9] ? 3'd4 : 3'd3, w[3], w[8:4],
                {w[13], w[11], w[10], w[2], w[1], w[0]}, 8'd0);        // R2 R3
  endfunction

  function automatic logic [22:0] actual();
    return pack(out_op, out_ptr_y, out_reg, out_disp, out_addr);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic set_mode(input logic red);
    @(negedge clk);
    in_valid = 1'b0;
    @(negedge clk);
    cfg_reduced = red;
    @(negedge clk);
  endtask

  // Present a word at a negedge; result is registered at the next posedge.
  task automatic send_check(input string req, input logic [15:0] w, input logic [22:0] exp);
    in_valid = 1'b1;
    in_word  = w;
    @(negedge clk);
    in_valid = 1'b0;
    check({req, " valid"}, {31'd0, out_valid}, 32'd1);
    check(req, {9'd0, actual()}, {9'd0, exp});
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 reset out_valid", {31'd0, out_valid}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check("R1 idle out_valid", {31'd0, out_valid}, 32'd0);
  endtask

  task automatic t_full_vectors();
    set_mode(1'b0);
    send_check("R3 A400 full",  16'hA400, pack(3'd3, 1'b0, 5'd0,  6'd40, 8'd0));
    send_check("R2 A8F5 full",  16'hA8F5, pack(3'd3, 1'b0, 5'd15, 6'd53, 8'd0));
    send_check("R2 AFFF full",  16'hAFFF, pack(3'd4, 1'b1, 5'd31, 6'd63, 8'd0));
    send_check("R2 8218 full",  16'h8218, pack(3'd4, 1'b1, 5'd1,  6'd0,  8'd0));
    send_check("R3 8400 full",  16'h8400, pack(3'd3, 1'b0, 5'd0,  6'd8,  8'd0));
  endtask

  task automatic t_reduced_vectors();
    set_mode(1'b1);
    send_check("R6 A400 reduced", 16'hA400, pack(3'd1, 1'b0, 5'd16, 6'd0, 8'hA0));
    send_check("R4 A8F5 reduced", 16'hA8F5, pack(3'd2, 1'b0, 5'd31, 6'd0, 8'h85));
    send_check("R4 AFFF reduced", 16'hAFFF, pack(3'd2, 1'b0, 5'd31, 6'd0, 8'h7F));
    send_check("R6 low edge A100", 16'hA100, pack(3'd1, 1'b0, 5'd16, 6'd0, 8'h40));
    send_check("R5 high edge A6FF", 16'hA6FF, pack(3'd1, 1'b0, 5'd31, 6'd0, 8'hBF));
    send_check("R7 8400 reduced illegal", 16'h8400, '0);
  endtask

  task automatic t_outside_region();
    set_mode(1'b0);
    send_check("R8 9400 full",  16'h9400, '0);
    send_check("R8 E400 full",  16'hE400, '0);
    send_check("R8 2400 full",  16'h2400, '0);
    set_mode(1'b1);
    send_check("R8 9400 reduced", 16'h9400, '0);
    send_check("R8 E7FF reduced", 16'hE7FF, '0);
  endtask

  task automatic t_sweep();
    for (int m = 0; m < 2; m++) begin
      set_mode(m[0]);
      for (int i = 0; i < 400; i++) begin
        logic [15:0] w;
        w = 16'(i * 16'h9E37 + 16'h1234);
        if (i % 3 == 0) w = {4'hA, w[11:0]};
        if (i % 3 == 1) w = {3'b100, 1'b0, w[11:0]};
        send_check(m[0] ? "R7 sweep reduced" : "R7 sweep full", w, expect_of(w, m[0]));
      end
    end
  endtask

  task automatic t_backpressure();
    set_mode(1'b1);
    out_ready = 1'b0;
    in_valid  = 1'b1;
    in_word   = 16'hA400;
    @(negedge clk);
    check("R9 first accepted", {9'd0, actual()}, {9'd0, pack(3'd1, 1'b0, 5'd16, 6'd0, 8'hA0)});
    check("R9 stall blocks input", {31'd0, in_ready}, 32'd0);
    in_word = 16'hA8F5;
    @(negedge clk);
    check("R9 held during stall", {9'd0, actual()}, {9'd0, pack(3'd1, 1'b0, 5'd16, 6'd0, 8'hA0)});
    check("R9 still valid", {31'd0, out_valid}, 32'd1);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R9 hand-over", {9'd0, actual()}, {9'd0, pack(3'd2, 1'b0, 5'd31, 6'd0, 8'h85)});
    @(negedge clk);
    check("R9 drained", {31'd0, out_valid}, 32'd0);
  endtask

  initial begin
    t_reset();
    t_full_vectors();
    t_reduced_vectors();
    t_outside_region();
    t_sweep();
    t_backpressure();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #(10 * 150000);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule